// File: doc/BRIEF.md
# Command Ring Fetch Controller

This block pulls 32-bit command words out of a ring buffer in memory and hands them one by one to a downstream command processor. Software sets up the ring through a small register port. It writes a 64-bit base address, a bound offset, and a write pointer (PUT). The engine keeps its own read pointer (GET) and fetches whenever GET differs from PUT, the control register reads zero, and GET lies below the bound. Each accepted word moves GET forward by one word.

Software cannot write GET directly. The only way to set it is to copy PUT into GET with a particular control value. Wrapping happens in the data itself. The ring bound is programmed one word past the data area, and that extra word holds a restart command, which moves GET back to the offset it carries. Restart commands are consumed inside the block and never reach the consumer.

The consumer side is a valid/ready stream. A word stays offered, unchanged, until it is taken. While a word is waiting, the engine issues no new memory request, so a stall at the consumer stops fetching. The memory side has one request in flight at most. A request is a single beat with its own valid/ready pair. The response is a single beat, with valid only.

Top module: `ring_fetch_ctrl`

## Requirements
- R1: After reset, CTRL reads 1 (stop only), and GET, PUT, START and END read 0. mem_req_valid and cmd_valid are low.
- R2: A CTRL write whose bits [2:0] are all set (bit0 stop, bit1 get-reset, bit2 init-get) copies PUT into GET and drops any word being offered. Any other CTRL value leaves GET unchanged.
- R3: A memory request is issued only when all of the following hold: CTRL reads 0, GET differs from PUT, GET is below the bound (END_HI nonzero or GET < END_LO), no request is outstanding, and no word is being offered.
- R4: The request address is {START_HI,START_LO} + GET.
- R5: A fetched word whose bits [31:28] are not 0x5 is offered on cmd_data. It is held stable until cmd_ready is high, and GET rises by 4 on that handshake.
- R6: A fetched word whose bits [31:28] are 0x5 is a restart. It sets GET to bits [27:0] times 4 and is never offered downstream.
- R7: If any nonzero CTRL value is written while a request is outstanding, the response to that request is discarded and GET does not change.
- R8: Fetching pauses when GET equals PUT. It resumes without further control writes once PUT is written to a different value.
- R9: Writes to PUT_HI and to the GET address have no effect, and PUT_HI reads 0.
- R10: Register addresses are: 0 CTRL, 1 START_LO, 2 START_HI, 3 END_LO, 4 END_HI, 5 PUT_LO, 6 PUT_HI, 7 GET. Reads are combinational and return the live GET and PUT at any time, including while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Register read data, combinational |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Consumer takes the word |
| cmd_data | output | 32 | Command word |

## Verification
The bench builds the block with ADDR_W = 48. This means START_HI keeps only 16 bits, and the base address used has a nonzero upper half, so both the truncated readback and the full-width address sum are exercised. The ring is 16 data words plus one restart slot. This small size lets random PUT moves wrap many times, and lets directed cases place GET exactly on the bound, on a restart with a nonzero target, and on a response that arrives after a stop.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_CTRL     = 3'd0;
  localparam logic [REG_AW-1:0] RA_START_LO = 3'd1;
  localparam logic [REG_AW-1:0] RA_START_HI = 3'd2;
  localparam logic [REG_AW-1:0] RA_END_LO   = 3'd3;
  localparam logic [REG_AW-1:0] RA_END_HI   = 3'd4;
  localparam logic [REG_AW-1:0] RA_PUT_LO   = 3'd5;
  localparam logic [REG_AW-1:0] RA_PUT_HI   = 3'd6;
  localparam logic [REG_AW-1:0] RA_GET      = 3'd7;

  localparam logic [3:0] RESTART_OPC = 4'h5;

  // control bits: [0] halt, [1] pointer reset, [2] pointer load
  localparam logic [2:0] CTRL_HALT_ONLY = 3'b001;
  localparam logic [2:0] CTRL_LOAD_PTR  = 3'b111;

  function automatic logic is_restart(input logic [31:0] w);
    return w[31:28] == RESTART_OPC;
  endfunction

  function automatic logic [31:0] restart_target(input logic [31:0] w);
    return {2'b00, w[27:0], 2'b00};
  endfunction
endpackage

// File: rtl/ring_fetch_regs.sv
module ring_fetch_regs
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [31:0]       get_i,
  output logic [2:0]        ctrl_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [31:0]       end_lo_o,
  output logic [31:0]       end_hi_o,
  output logic [31:0]       put_o,
  output logic              get_load_o,
  output logic              ctrl_nz_wr_o
);
  localparam int HI_W = ADDR_W - 32;

  logic [2:0]      ctrl_q;
  logic [31:0]     start_lo_q;
  logic [HI_W-1:0] start_hi_q;
  logic [31:0]     end_lo_q;
  logic [31:0]     end_hi_q;
  logic [31:0]     put_q;
  logic            ctrl_hit;

  assign ctrl_hit     = wr_en && (wr_addr == RA_CTRL);
  assign get_load_o   = ctrl_hit && (wr_data[2:0] == CTRL_LOAD_PTR);
  assign ctrl_nz_wr_o = ctrl_hit && (wr_data[2:0] != 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_HALT_ONLY;
      start_lo_q <= '0;
      start_hi_q <= '0;
      end_lo_q   <= '0;
      end_hi_q   <= '0;
      put_q      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_CTRL:     ctrl_q     <= wr_data[2:0];
        RA_START_LO: start_lo_q <= wr_data;
        RA_START_HI: start_hi_q <= wr_data[HI_W-1:0];
        RA_END_LO:   end_lo_q   <= wr_data;
        RA_END_HI:   end_hi_q   <= wr_data;
        RA_PUT_LO:   put_q      <= wr_data;
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      RA_CTRL:     rd_data = {29'd0, ctrl_q};
      RA_START_LO: rd_data = start_lo_q;
      RA_START_HI: rd_data = 32'(start_hi_q);
      RA_END_LO:   rd_data = end_lo_q;
      RA_END_HI:   rd_data = end_hi_q;
      RA_PUT_LO:   rd_data = put_q;
      RA_GET:      rd_data = get_i;
      default:     rd_data = 32'd0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign start_o  = {start_hi_q, start_lo_q};
  assign end_lo_o = end_lo_q;
  assign end_hi_o = end_hi_q;
  assign put_o    = put_q;
endmodule

// File: rtl/ring_fetch_outbuf.sv
module ring_fetch_outbuf #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              flush,
  output logic              busy,
  output logic              accept,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_data
);
  logic              vld_q;
  logic [WORD_W-1:0] dat_q;

  assign accept    = vld_q && cmd_ready;
  assign busy      = vld_q;
  assign cmd_valid = vld_q;
  assign cmd_data  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= load_data;
    end else if (accept) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_fetch_engine.sv
module ring_fetch_engine
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ctrl,
  input  logic [ADDR_W-1:0] start,
  input  logic [31:0]       end_lo,
  input  logic [31:0]       end_hi,
  input  logic [31:0]       put,
  input  logic              get_load,
  input  logic              ctrl_nz_wr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              buf_busy,
  input  logic              buf_accept,
  output logic              buf_load,
  output logic [31:0]       get_o
);
  logic        pend_q, drop_q;
  logic [31:0] get_q;
  logic        run, below_end, req_fire, rsp_take, rsp_keep, rsp_restart;

  assign run         = (ctrl == 3'b000);
  assign below_end   = (end_hi != 32'd0) || (get_q < end_lo);
  assign mem_req_valid = run && (get_q != put) && below_end && !pend_q && !buf_busy;
  assign mem_req_addr  = start + ADDR_W'(get_q);
  assign req_fire    = mem_req_valid && mem_req_ready;
  assign rsp_take    = mem_rsp_valid && pend_q;
  assign rsp_keep    = rsp_take && !drop_q && !ctrl_nz_wr && run;
  assign rsp_restart = is_restart(mem_rsp_data);
  assign buf_load    = rsp_keep && !rsp_restart;
  assign get_o       = get_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (req_fire)      pend_q <= 1'b1;
      else if (rsp_take) pend_q <= 1'b0;
      if (rsp_take)      drop_q <= 1'b0;
      else if (ctrl_nz_wr && (pend_q || req_fire)) drop_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      get_q <= '0;
    else if (get_load)               get_q <= put;
    else if (rsp_keep && rsp_restart) get_q <= restart_target(mem_rsp_data);
    else if (buf_accept)             get_q <= get_q + 32'd4;
  end
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
  import ring_fetch_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic [2:0]        reg_rd_addr,
  output logic [31:0]       reg_rd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_data
);
  logic [2:0]        ctrl_q;
  logic [ADDR_W-1:0] start_q;
  logic [31:0]       end_lo_q, end_hi_q, put_q, get_q;
  logic              get_load, ctrl_nz_wr, buf_busy, buf_accept, buf_load;

  ring_fetch_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data), .get_i(get_q),
    .ctrl_o(ctrl_q), .start_o(start_q), .end_lo_o(end_lo_q), .end_hi_o(end_hi_q),
    .put_o(put_q), .get_load_o(get_load), .ctrl_nz_wr_o(ctrl_nz_wr)
  );

  ring_fetch_engine #(.ADDR_W(ADDR_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .start(start_q),
    .end_lo(end_lo_q), .end_hi(end_hi_q), .put(put_q),
    .get_load(get_load), .ctrl_nz_wr(ctrl_nz_wr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .buf_busy(buf_busy), .buf_accept(buf_accept), .buf_load(buf_load), .get_o(get_q)
  );

  ring_fetch_outbuf #(.WORD_W(32)) outbuf_i (
    .clk(clk), .rst_n(rst_n), .load(buf_load), .load_data(mem_rsp_data),
    .flush(get_load), .busy(buf_busy), .accept(buf_accept),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );
endmodule

// File: rtl/ring_fetch_chk.sv
module ring_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_data,
  input logic        mem_req_valid,
  input logic [2:0]  ctrl_q,
  input logic [31:0] get_q,
  input logic [31:0] put_q,
  input logic        get_load
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !get_load |=> cmd_valid && $stable(cmd_data)); // R5
  AST_ONE_WORD_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_req_valid); // R5
  AST_GET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !get_load |=> get_q == $past(get_q) + 32'd4); // R5
  AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (ctrl_q == 3'b000) && (get_q != put_q)); // R3
  AST_GET_FROM_PUT: assert property (@(posedge clk) disable iff (!rst_n)
    get_load |=> get_q == $past(put_q)); // R2
  AST_LOAD_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    get_load |=> !cmd_valid); // R2
endmodule

bind ring_fetch_ctrl ring_fetch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .mem_req_valid(mem_req_valid), .ctrl_q(ctrl_q),
  .get_q(get_q), .put_q(put_q), .get_load(get_load)
);

// File: tb/ring_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module ring_fetch_ctrl_tb_top;
  import ring_fetch_pkg::*;
  localparam int AW = 48;
  localparam logic [AW-1:0] BASE = 48'h0002_8000_0100;
  localparam int RW = 16;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [2:0] reg_wr_addr = 0, reg_rd_addr = 0;
  logic [31:0] reg_wr_data = 0, reg_rd_data;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0, cmd_valid, cmd_ready = 0;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_rsp_data = 0, cmd_data;

  int checks = 0, fails = 0;
  logic [31:0] mem_w [0:RW];
  logic [31:0] exp_get = 0;
  bit force_ready = 0, bp_on = 0, no_req = 0, rsp_armed = 0;
  int rsp_delay = 0, wait_cnt = 0;
  logic [31:0] rsp_word = 0;

  always #2.5 clk = ~clk;

  ring_fetch_ctrl #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] data_word();
    logic [31:0] w = $urandom;
    if (w[31:28] == RESTART_OPC) w[31:28] = 4'h4;
    return w;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_addr = a; #1 d = reg_rd_data;
  endtask

  task automatic wait_get(input logic [31:0] tgt);
    logic [31:0] g;
    for (int i = 0; i < 3000; i++) begin
      rd(RA_GET, g);
      if (g == tgt && !cmd_valid) break;
    end
  endtask

  // memory model: one response, rsp_delay cycles after acceptance
  always @(negedge clk) begin
    logic [AW-1:0] ofs;
    mem_rsp_valid = 0;
    if (rsp_armed) begin
      if (wait_cnt == 0) begin mem_rsp_valid = 1; mem_rsp_data = rsp_word; rsp_armed = 0; end
      else wait_cnt--;
    end
    mem_req_ready = force_ready || ($urandom % 4 != 0);
    if (rst_n && mem_req_valid) begin
      if (no_req) chk("R3 request while stopped", 1, 0);
      if (mem_req_ready) begin
        ofs = mem_req_addr - BASE;
        chk("R4 address inside ring", {63'd0, (ofs <= AW'(RW*4)) && (ofs[1:0] == 2'b00)}, 1);
        rsp_word = mem_w[int'(ofs[7:2]) % (RW + 1)];
        rsp_armed = 1; wait_cnt = rsp_delay;
      end
    end
  end

  // consumer model and stream scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cmd_ready = bp_on ? 1'b0 : ($urandom % 3 != 0);
      if (cmd_valid && cmd_ready) begin
        for (int k = 0; k < 4 && is_restart(mem_w[int'(exp_get >> 2) % (RW + 1)]); k++)
          exp_get = restart_target(mem_w[int'(exp_get >> 2) % (RW + 1)]); // R6
        chk("R5 word order", cmd_data, mem_w[int'(exp_get >> 2) % (RW + 1)]);
        exp_get += 4;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed));
    for (int i = 0; i < RW; i++) mem_w[i] = data_word();
    mem_w[RW] = {RESTART_OPC, 28'd0};
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(RA_CTRL, v);  chk("R1 ctrl", v, 1);
    rd(RA_GET, v);   chk("R1 get", v, 0);
    rd(RA_PUT_LO, v); chk("R1 put", v, 0);
    rd(RA_END_LO, v); chk("R1 end", v, 0);
    chk("R1 no request", mem_req_valid, 0);
    chk("R1 no word", cmd_valid, 0);
    // R10 programming and readback
    wr(RA_START_LO, BASE[31:0]);
    wr(RA_START_HI, 32'hFFFF_0000 | 32'(BASE[AW-1:32]));
    wr(RA_END_LO, 32'(RW * 4 + 4));
    rd(RA_START_HI, v); chk("R10 start hi truncated", v, 32'(BASE[AW-1:32]));
    // R9 ignored writes
    wr(RA_PUT_HI, 32'hDEAD); rd(RA_PUT_HI, v); chk("R9 put hi", v, 0);
    wr(RA_GET, 32'h1234);    rd(RA_GET, v);    chk("R9 get read only", v, 0);
    // R2 pointer load
    wr(RA_PUT_LO, 32'h20); wr(RA_CTRL, 3'b111); exp_get = 32'h20;
    rd(RA_GET, v); chk("R2 load", v, 32'h20);
    wr(RA_PUT_LO, 32'h30); wr(RA_CTRL, 3'b101);
    rd(RA_GET, v); chk("R2 partial ctrl no load", v, 32'h20);
    // R3 stopped: no requests; R10 live read while stopped
    no_req = 1;
    wr(RA_CTRL, 3'b001); repeat (10) @(negedge clk);
    wr(RA_CTRL, 3'b010); repeat (10) @(negedge clk);
    wr(RA_CTRL, 3'b001); no_req = 0;
    rd(RA_PUT_LO, v); chk("R10 put live", v, 32'h30);
    rd(RA_GET, v);    chk("R10 get live", v, 32'h20);
    // R4 address
    wr(RA_CTRL, 0); #1;
    chk("R4 req valid", mem_req_valid, 1);
    chk("R4 req addr", mem_req_addr, BASE + AW'(32'h20));
    wait_get(32'h30); rd(RA_GET, v); chk("R8 drained", v, 32'h30);
    // R5 back-pressure
    bp_on = 1; wr(RA_PUT_LO, 32'h38); repeat (8) @(negedge clk);
    chk("R5 word held", cmd_valid, 1);
    chk("R5 held data", cmd_data, mem_w[12]);
    chk("R5 no request while held", mem_req_valid, 0);
    rd(RA_GET, v); chk("R5 get waits", v, 32'h30);
    bp_on = 0; wait_get(32'h38); rd(RA_GET, v); chk("R5 after release", v, 32'h38);
    // R6 wrap through restart at offset 0
    wr(RA_PUT_LO, 32'h08); wait_get(32'h08); rd(RA_GET, v); chk("R6 wrap", v, 32'h08);
    // R6 restart with nonzero target
    wr(RA_PUT_LO, 32'h3C); wait_get(32'h3C);
    mem_w[RW] = {RESTART_OPC, 28'd3};
    wr(RA_PUT_LO, 32'h10); wait_get(32'h10); rd(RA_GET, v); chk("R6 target", v, 32'h10);
    mem_w[RW] = {RESTART_OPC, 28'd0};
    // R7 discard after stop
    force_ready = 1; rsp_delay = 6;
    wr(RA_PUT_LO, 32'h18); @(negedge clk); wr(RA_CTRL, 3'b001);
    repeat (12) @(negedge clk);
    chk("R7 no word", cmd_valid, 0);
    rd(RA_GET, v); chk("R7 get unchanged", v, 32'h10);
    force_ready = 0; rsp_delay = 0;
    wr(RA_CTRL, 0); wait_get(32'h18); rd(RA_GET, v); chk("R7 refetch", v, 32'h18);
    // R3 bound
    wr(RA_END_LO, 32'h20); wr(RA_PUT_LO, 32'h30); repeat (30) @(negedge clk);
    rd(RA_GET, v); chk("R3 stop at bound", v, 32'h20);
    chk("R3 no request at bound", mem_req_valid, 0);
    wr(RA_END_LO, 32'(RW * 4 + 4)); wait_get(32'h30); rd(RA_GET, v); chk("R3 bound lifted", v, 32'h30);
    // R2 resume from explicit position
    wr(RA_CTRL, 3'b001); wr(RA_PUT_LO, 32'h24); wr(RA_CTRL, 3'b111); exp_get = 32'h24;
    wr(RA_CTRL, 3'b001); wr(RA_PUT_LO, 32'h2C); wr(RA_CTRL, 0);
    wait_get(32'h2C); rd(RA_GET, v); chk("R2 resume", v, 32'h2C);
    // R8 random PUT moves
    for (int it = 0; it < 40; it++) begin
      logic [31:0] p = ($urandom % RW) * 4;
      if (it % 8 == 3) rsp_delay = $urandom % 3; else rsp_delay = 0;
      wr(RA_PUT_LO, p); wait_get(p);
      rd(RA_GET, v); chk("R8 random put", v, p);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule